// File: doc/BRIEF.md
# Serial ADC Conversion Output Port

This block is the digital face of a sampling converter. A host pulls the active-low conversion-start input low. The block then raises a busy flag for a fixed number of system clocks that stands in for the conversion time. When busy drops, it captures a 14-bit result from a sample input and places it in a 16-bit output shift register. The frame is two zero bits followed by the result, most significant bit first.

The host reads the frame with 16 pulses on an external serial clock. That clock idles high. The most significant frame bit is on the data line as soon as busy falls. Each rising serial-clock edge moves the line to the next bit, so the host captures each bit on the falling edge that starts the next pulse.

The serial data line is driven only from the end of a conversion until the 16th rising edge of that read. At all other times it is high-impedance. Every new conversion start clears the shift register. A read that runs across a conversion start is therefore cut short.

Both the conversion-start input and the serial clock are asynchronous to the system clock. Each passes through a two-flop synchroniser before its edge is detected. Each must therefore stay in each level for at least two system clocks.

Top module: `serial_adc_port`

## Requirements
- R1: After reset, `busy` is 0, `sdata_oe` is 0 and `sdata` is high-impedance.
- R2: A falling edge on `conv_start_n` sets `busy` to 1 after the two-flop synchroniser. `busy` then stays high for exactly `CONV_CYCLES` system clocks.
- R3: In the cycle `busy` falls, the frame `{2'b00, sample_in}` is loaded. In the same cycle `sdata_oe` goes to 1 and `sdata` shows frame bit 15.
- R4: After k rising edges of `sclk` since the load (k = 1..15), `sdata` shows frame bit 15-k. The frame is sent MSB first.
- R5: The 16th rising edge of `sclk` after a load sets `sdata_oe` to 0, and `sdata` becomes high-impedance.
- R6: Further `sclk` rising edges after the 16th never set `sdata_oe` again. The next conversion still delivers a complete and correct frame.
- R7: A falling edge on `conv_start_n` during a read clears the shift register and sets `sdata_oe` to 0. The read stops.
- R8: `sclk` edges while `busy` is high, or before any conversion has ended, leave `sdata_oe` at 0. They do not disturb the next frame.
- R9: A falling edge on `conv_start_n` while `busy` is high restarts the timer. `busy` stays high for `CONV_CYCLES` clocks from the detection of the later edge, without dropping in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start_n | input | 1 | Asynchronous active-low conversion start; the falling edge triggers |
| sample_in | input | SAMPLE_W | Conversion result, captured when busy falls |
| sclk | input | 1 | Asynchronous serial clock from the host, idle high |
| busy | output | 1 | High while a conversion is in progress |
| sdata | output | 1 | Serial data, high-impedance when not enabled |
| sdata_oe | output | 1 | High while `sdata` is driven |

## Verification
On every cycle, the assertions check the following:
- A detected start always raises busy and reloads the timer.
- An expired timer always drops busy.
- A load always enables the output with the zero-padded sample.
- The 16th shift and every start always disable the output.
- The output never turns on without a load.

Only the bench scenarios can show the end-to-end results. These are the exact busy length seen at the ports, the bit order of whole frames for random and extreme samples, and that extra clocks, clocks during a conversion and a read cut by a new start leave the next frame intact.

// File: rtl/adc_port_pkg.sv
// Package: shared types for the serial ADC conversion output port.
// Assumes the frame is wider than the sample, so the padding is at least one bit.
package adc_port_pkg;
    // Events passed from the timer to the frame shifter
    typedef struct packed {
        logic start;   // conversion-start edge detected this cycle
        logic done;    // conversion finishes at the coming edge
    } conv_evt_t;
endpackage

// File: rtl/edge_sync.sv
// Module: edge_sync
// Brings an asynchronous input through STAGES flops and gives a one-cycle
// pulse on the chosen edge. Assumes the input holds each level for at
// least STAGES system clocks. RST_VAL is the idle level of the input.
module edge_sync #(
    parameter int   STAGES  = 2,
    parameter bit   FALL    = 1'b1,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic pulse
);
    logic [STAGES:0] pipe;

    // Shift the input through the synchroniser and one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {(STAGES+1){RST_VAL}};
        else        pipe <= {pipe[STAGES-1:0], async_in};
    end

    assign level = pipe[STAGES-1];

    generate
        if (FALL) begin : g_fall
            // Pulse when the synchronised level goes from 1 to 0
            assign pulse = pipe[STAGES] & ~pipe[STAGES-1];
        end else begin : g_rise
            // Pulse when the synchronised level goes from 0 to 1
            assign pulse = ~pipe[STAGES] & pipe[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/conv_timer.sv
// Module: conv_timer
// Holds busy for CONV_CYCLES clocks after each start pulse. A start pulse
// during busy reloads the count. done is high in the last busy cycle.
// Assumes CONV_CYCLES >= 1.
module conv_timer #(
    parameter int CONV_CYCLES = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CONV_CYCLES + 1);

    logic [CW-1:0] remain;

    assign done = busy && (remain == '0) && !start;

    // Load on start, count down while busy, release at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= CW'(CONV_CYCLES - 1);
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

    // R2
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R9
    start_reloads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (remain == CW'(CONV_CYCLES - 1)));
    // R2
    expiry_drops_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && remain == '0 && !start) |=> !busy);
endmodule

// File: rtl/frame_shifter.sv
// Module: frame_shifter
// The output shift register. A clear empties it and turns the output off.
// A load places the zero-padded sample in it and turns the output on.
// Each shift moves it one bit towards the MSB. The FRAME_W-th shift turns
// the output off and empties it, and later shifts run on with the output off.
// Assumes FRAME_W > SAMPLE_W and that clear and load never coincide.
module frame_shifter #(
    parameter int SAMPLE_W = 14,
    parameter int FRAME_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                shift,
    output logic                bit_out,
    output logic                oe
);
    localparam int PAD = FRAME_W - SAMPLE_W;
    localparam int CW  = $clog2(FRAME_W);

    logic [FRAME_W-1:0] shreg;
    logic [CW-1:0]      cnt;

    assign bit_out = shreg[FRAME_W-1];

    // Clear, load or shift the frame, tracking the shifts since the load
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            shreg <= '0;
            cnt   <= '0;
            oe    <= 1'b0;
        end else if (load) begin
            shreg <= {{PAD{1'b0}}, sample};
            cnt   <= '0;
            oe    <= 1'b1;
        end else if (shift) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(FRAME_W - 1)) begin
                shreg <= '0;
                oe    <= 1'b0;
            end else begin
                shreg <= {shreg[FRAME_W-2:0], 1'b0};
            end
        end
    end

    // R3
    load_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (oe && shreg == {{PAD{1'b0}}, $past(sample)}));
    // R5
    last_shift_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && shift && !clear && !load && cnt == CW'(FRAME_W - 1)) |=> !oe);
    // R7
    clear_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !oe);
    // R8
    no_enable_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe && !load) |=> !oe);
endmodule

// File: rtl/serial_adc_port.sv
// Module: serial_adc_port (top)
// Digital side of a sampling converter's conversion and readout. It
// synchronises the conversion-start input and the serial clock, times the
// conversion, and drives the zero-padded result MSB first on a tri-state line.
// Assumes both asynchronous inputs hold each level for at least
// SYNC_STAGES system clocks.
module serial_adc_port #(
    parameter int SAMPLE_W    = 14,
    parameter int FRAME_W     = 16,
    parameter int CONV_CYCLES = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_start_n,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                sclk,
    output logic                busy,
    output tri                  sdata,
    output logic                sdata_oe
);
    import adc_port_pkg::*;

    conv_evt_t evt;
    logic      conv_level;
    logic      sclk_level;
    logic      sclk_rise;
    logic      data_bit;

    // Conversion start: falling-edge detect after the synchroniser
    edge_sync #(.STAGES(SYNC_STAGES), .FALL(1'b1), .RST_VAL(1'b1)) u_conv_sync (
        .clk(clk), .rst_n(rst_n), .async_in(conv_start_n),
        .level(conv_level), .pulse(evt.start)
    );

    // Serial clock: rising-edge detect after the synchroniser
    edge_sync #(.STAGES(SYNC_STAGES), .FALL(1'b0), .RST_VAL(1'b1)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sclk),
        .level(sclk_level), .pulse(sclk_rise)
    );

    conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(evt.start),
        .busy(busy), .done(evt.done)
    );

    frame_shifter #(.SAMPLE_W(SAMPLE_W), .FRAME_W(FRAME_W)) u_shifter (
        .clk(clk), .rst_n(rst_n), .clear(evt.start), .load(evt.done),
        .sample(sample_in), .shift(sclk_rise), .bit_out(data_bit), .oe(sdata_oe)
    );

    // Tri-state driver for the serial data line
    assign sdata = sdata_oe ? data_bit : 1'bz;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !sdata_oe));
    // R8
    off_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !evt.done) |=> !sdata_oe);
endmodule

// File: tb/serial_adc_port_bench.sv
// Bench: constrained-random samples from a fixed seed, plus directed corners
module serial_adc_port_bench;
    localparam int CLK_PERIOD  = 10;
    localparam int CONV_CYCLES = 20;
    localparam int SAMPLE_W    = 14;
    localparam int FRAME_W     = 16;
    localparam int WATCHDOG    = 150000;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                conv_start_n = 1'b1;
    logic [SAMPLE_W-1:0] sample_in = '0;
    logic                sclk = 1'b1;
    logic                busy;
    tri                  sdata;
    logic                sdata_oe;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    serial_adc_port #(.SAMPLE_W(SAMPLE_W), .FRAME_W(FRAME_W),
                      .CONV_CYCLES(CONV_CYCLES), .SYNC_STAGES(2)) u_serial_adc_port (
        .clk(clk), .rst_n(rst_n), .conv_start_n(conv_start_n), .sample_in(sample_in),
        .sclk(sclk), .busy(busy), .sdata(sdata), .sdata_oe(sdata_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog got %0d cycles exp <= %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic logic [FRAME_W-1:0] exp_frame(input logic [SAMPLE_W-1:0] s);
        return {{(FRAME_W-SAMPLE_W){1'b0}}, s};
    endfunction

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic start_pulse();
        @(negedge clk) conv_start_n = 1'b0;
        repeat (3) @(negedge clk);
        conv_start_n = 1'b1;
    endtask

    task automatic sclk_pulse();
        @(negedge clk) sclk = 1'b0;
        repeat (3) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Count the negedges at which busy is high, until it drops
    task automatic busy_len(output int n);
        n = 0;
        while (!busy && n < 10) begin @(negedge clk); n++; end
        n = 0;
        while (busy && n < 10 * CONV_CYCLES) begin n++; @(negedge clk); end
    endtask

    // Convert one sample and check the busy length (R2)
    task automatic convert(input logic [SAMPLE_W-1:0] s);
        int n;
        sample_in = s;
        start_pulse();
        busy_len(n);
        check(n == CONV_CYCLES, "R2 busy length", n, CONV_CYCLES);
    endtask

    // Read the first nbits of a frame; the check at k rises covers R3 (k=0) and R4
    task automatic read_bits(input logic [FRAME_W-1:0] f, input int nbits);
        for (int k = 0; k < nbits; k++) begin
            if (k > 0) sclk_pulse();
            check(sdata_oe === 1'b1, k == 0 ? "R3 oe on" : "R4 oe on", sdata_oe, 1);
            check(sdata === f[FRAME_W-1-k], k == 0 ? "R3 first bit" : "R4 bit",
                  sdata, f[FRAME_W-1-k]);
        end
    endtask

    task automatic full_read(input logic [SAMPLE_W-1:0] s);
        read_bits(exp_frame(s), FRAME_W);
        sclk_pulse();
        check(sdata_oe === 1'b0, "R5 off after 16th", sdata_oe, 0);
    endtask

    initial begin
        logic [SAMPLE_W-1:0] s;
        int n;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy === 1'b0, "R1 busy", busy, 0);
        check(sdata_oe === 1'b0, "R1 oe", sdata_oe, 0);

        // R8 clocks before any conversion
        repeat (3) sclk_pulse();
        check(sdata_oe === 1'b0, "R8 pre-conversion", sdata_oe, 0);

        // Directed extremes
        convert(14'h3FFF); full_read(14'h3FFF);
        convert(14'h0000); full_read(14'h0000);
        convert(14'h2AAA); full_read(14'h2AAA);
        convert(14'h1555); full_read(14'h1555);

        // R6 extra clocks after the 16th
        repeat (3) begin
            sclk_pulse();
            check(sdata_oe === 1'b0, "R6 extra clock", sdata_oe, 0);
        end
        s = 14'h2001;
        convert(s); full_read(s);

        // Random frames
        for (int i = 0; i < 8; i++) begin
            s = SAMPLE_W'($urandom);
            convert(s); full_read(s);
        end

        // R7 start in the middle of a read
        s = 14'h3C3C;
        convert(s);
        read_bits(exp_frame(s), 7);
        start_pulse();
        check(sdata_oe === 1'b0, "R7 read cut", sdata_oe, 0);
        // R8 clocks while busy
        sclk_pulse();
        check(sdata_oe === 1'b0, "R8 clock while busy", sdata_oe, 0);
        s = 14'h0F0F;
        sample_in = s;
        while (busy) @(negedge clk);
        full_read(s);

        // R9 restart during busy: busy stays up CONV_CYCLES+2 negedges after the second drive
        sample_in = 14'h1234;
        start_pulse();
        repeat (4) @(negedge clk);
        conv_start_n = 1'b0;
        n = 0;
        for (int j = 0; j < 10 * CONV_CYCLES; j++) begin
            @(negedge clk);
            if (j == 3) conv_start_n = 1'b1;
            if (!busy) break;
            n++;
        end
        check(n == CONV_CYCLES + 2, "R9 restart length", n, CONV_CYCLES + 2);
        full_read(14'h1234);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule